// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

The controller decides which of ten interrupt sources the processor should service next. Eight of them are ordinary sources. Software gates each one with an enable bit and ranks it through a programmable priority map. The two others have fixed ranks: a non-maskable source and a software trap. Requests are latched as pending. A request is offered to the processor only when its rank is strictly above every service that is already running. This lets a more urgent request interrupt a running handler, and the interrupted handler resumes when the urgent one returns.

The priority map is a 24-bit word split into eight 3-bit slots, one per priority level. Each slot holds the code of the source placed at that level, so software programs level-to-source rather than source-to-level. The processor sees a request line, the identifier of the source and its rank. It answers with acknowledge and return strobes. It also drives a global enable and a command that discards a pending request by source code. Vector fetch and context saving belong to the processor.

Top module: `pic_prio_ctrl`

## Requirements
- R1: After reset every enable bit is 0, no request is pending, nothing is in service, `irq` is 0, and level slot L holds code L.
- R2: A configuration write to address 0 loads the enable bits; bit s set to 1 enables source s. A request from a disabled source stays pending and is offered as soon as its bit is set. Writes to addresses 1, 5, 6 and 7 change nothing.
- R3: Writes to addresses 2, 3 and 4 load bits 7:0, 15:8 and 23:16 of the map. Slot L is map bits 3L+2..3L and names the source at level L. Level 7 is the highest. Among enabled pending ordinary sources, the one whose level is highest is offered with `irq_id` = its code (0..7) and `irq_rank` = its level.
- R4: While `glob_en` is 0, no ordinary source is offered; its requests stay pending.
- R5: `ack` while `irq` is 1 clears the offered request and marks its rank in service. `ack` while `irq` is 0 has no effect.
- R6: A request is offered only if its rank is strictly above the highest rank in service. `rti` removes the highest rank in service, so a lower pending or interrupted service may then proceed.
- R7: The non-maskable source has `irq_id` 8 and rank 8. It ignores the enable bits and `glob_en`, and it is offered above every ordinary source.
- R8: The trap has `irq_id` 9 and rank 9. It ignores `glob_en`, and while it is in service no other request is offered.
- R9: `clr_valid` with `clr_code` c discards the pending request of source c, unless the level of c is in service, in which case the command has no effect. Other sources are untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address (0 enables, 2..4 priority map) |
| cfg_wdata | input | 8 | Configuration write data |
| src_req | input | 8 | Request pulses of the ordinary sources, bit s = source code s |
| nmi_req | input | 1 | Non-maskable request pulse |
| trap_req | input | 1 | Software trap request pulse |
| glob_en | input | 1 | Global enable for ordinary sources |
| ack | input | 1 | Processor accepts the offered request |
| rti | input | 1 | Processor returns from the current service |
| clr_valid | input | 1 | Discard-pending command strobe |
| clr_code | input | 3 | Source code to discard |
| irq | output | 1 | A request is offered |
| irq_id | output | 4 | Identifier of the offered request (0..7, 8 non-maskable, 9 trap) |
| irq_rank | output | 4 | Rank of the offered request (level 0..7, 8, 9) |

## Verification
The hardest case to reach from the ports is a discard command aimed at a source that is in service while the same source has a fresh pending request. A clear there must leave the request intact. The bench gets there by acknowledging a source, pulsing the same source again so it pends behind its own service, issuing the clear, and then returning. The request must reappear. The other hard case is a three-deep chain: an ordinary service, then the non-maskable source over it, then the trap over that. The bench unwinds it one return at a time. For nesting, the bench sweeps every ordered pair of ordinary sources under four priority permutations and checks both simultaneous arrival and preemption of a running service.

// File: rtl/pic_pkg.sv
// Package: shared sizes, identifiers and helpers of the priority interrupt
// controller. Assumes eight ordinary sources, so a source code fits the
// 3-bit level slots of the priority map.
package pic_pkg;
    localparam int SRC_N     = 8;
    localparam int CODE_W    = $clog2(SRC_N);
    localparam int MAP_W     = SRC_N * CODE_W;
    localparam int MAP_BYTES = MAP_W / 8;
    localparam int RANK_N    = SRC_N + 2;
    localparam int ID_W      = $clog2(RANK_N);
    localparam int ADDR_W    = 3;
    localparam int ADDR_MASK = 0;
    localparam int ADDR_MAP0 = 2;
    localparam int RANK_NMI  = SRC_N;
    localparam int RANK_TRAP = SRC_N + 1;

    // Highest set index of a rank vector (0 when empty).
    function automatic logic [ID_W-1:0] top_index(input logic [RANK_N-1:0] v);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = 0; i < RANK_N; i++) begin
            if (v[i]) r = ID_W'(i);
        end
        return r;
    endfunction

    // Identity mapping: level slot L holds source code L.
    function automatic logic [MAP_W-1:0] default_map();
        logic [MAP_W-1:0] m;
        m = '0;
        for (int l = 0; l < SRC_N; l++) begin
            m[l*CODE_W +: CODE_W] = CODE_W'(l);
        end
        return m;
    endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
// Configuration registers: the enable word and the byte-wide priority map.
// Also decodes the map into a one-hot source-to-level table and an encoded
// level per source. Assumes the map is a permutation whenever it is used.
module pic_cfg_regs
    import pic_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [ADDR_W-1:0]              cfg_addr,
    input  logic [7:0]                     cfg_wdata,
    output logic [SRC_N-1:0]               mask_q,
    output logic [MAP_W-1:0]               map_q,
    output logic [SRC_N-1:0][SRC_N-1:0]    src_lvl_oh,
    output logic [SRC_N-1:0][CODE_W-1:0]   src_lvl
);
    localparam logic [MAP_W-1:0] MAP_RST = default_map();

    logic [7:0] map_byte [MAP_BYTES];

    // Enable word register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (cfg_we && cfg_addr == ADDR_W'(ADDR_MASK)) begin
            mask_q <= cfg_wdata[SRC_N-1:0];
        end
    end

    genvar b, s, l;
    generate
        for (b = 0; b < MAP_BYTES; b++) begin : g_map_byte
            // One priority-map byte, reset to the identity mapping.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    map_byte[b] <= MAP_RST[b*8 +: 8];
                end else if (cfg_we && cfg_addr == ADDR_W'(ADDR_MAP0 + b)) begin
                    map_byte[b] <= cfg_wdata;
                end
            end
            assign map_q[b*8 +: 8] = map_byte[b];
        end

        for (s = 0; s < SRC_N; s++) begin : g_src
            for (l = 0; l < SRC_N; l++) begin : g_lvl
                assign src_lvl_oh[s][l] = (map_q[l*CODE_W +: CODE_W] == CODE_W'(s));
            end
        end
    endgenerate

    // Encode each source's one-hot level row into a level number.
    always_comb begin
        for (int si = 0; si < SRC_N; si++) begin
            src_lvl[si] = '0;
            for (int li = 0; li < SRC_N; li++) begin
                if (src_lvl_oh[si][li]) src_lvl[si] = src_lvl[si] | CODE_W'(li);
            end
        end
    end
endmodule

// File: rtl/pic_pending.sv
// Pending request latches for the ordinary sources, the non-maskable source
// and the trap. A request pulse sets its latch; acknowledge or an unblocked
// discard command clears it. A set in the same cycle wins over a clear.
module pic_pending
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_N-1:0]    src_req,
    input  logic                nmi_req,
    input  logic                trap_req,
    input  logic                ack_fire,
    input  logic [ID_W-1:0]     ack_id,
    input  logic                clr_valid,
    input  logic [CODE_W-1:0]   clr_code,
    input  logic                clr_block,
    output logic [SRC_N-1:0]    pend_q,
    output logic                nmi_pend_q,
    output logic                trap_pend_q
);
    logic [SRC_N-1:0] pend_n;
    logic             nmi_n;
    logic             trap_n;

    // Next pending state: apply clears first, then new requests.
    always_comb begin
        pend_n = pend_q;
        nmi_n  = nmi_pend_q;
        trap_n = trap_pend_q;
        if (ack_fire) begin
            if (ack_id < ID_W'(SRC_N)) pend_n[ack_id[CODE_W-1:0]] = 1'b0;
            if (ack_id == ID_W'(RANK_NMI)) nmi_n = 1'b0;
            if (ack_id == ID_W'(RANK_TRAP)) trap_n = 1'b0;
        end
        if (clr_valid && !clr_block) pend_n[clr_code] = 1'b0;
        pend_n = pend_n | src_req;
        nmi_n  = nmi_n | nmi_req;
        trap_n = trap_n | trap_req;
    end

    // Pending registers, empty after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= '0;
            nmi_pend_q  <= 1'b0;
            trap_pend_q <= 1'b0;
        end else begin
            pend_q      <= pend_n;
            nmi_pend_q  <= nmi_n;
            trap_pend_q <= trap_n;
        end
    end
endmodule

// File: rtl/pic_insvc.sv
// In-service tracker. Nesting only ever stacks strictly rising ranks, so the
// stack of active services is kept as one bit per rank; its top is the
// highest set bit. A return pops the top, an acknowledge pushes a rank.
module pic_insvc
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [ID_W-1:0]     push_rank,
    input  logic                pop,
    output logic [RANK_N-1:0]   insvc_q,
    output logic                insvc_any,
    output logic [ID_W-1:0]     insvc_top
);
    logic [RANK_N-1:0] insvc_n;

    assign insvc_any = |insvc_q;
    assign insvc_top = top_index(insvc_q);

    // Next in-service set: pop the top first, then push the new rank.
    always_comb begin
        insvc_n = insvc_q;
        if (pop && insvc_any) insvc_n[insvc_top] = 1'b0;
        if (push) insvc_n[push_rank] = 1'b1;
    end

    // In-service register, empty after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insvc_q <= '0;
        end else begin
            insvc_q <= insvc_n;
        end
    end
endmodule

// File: rtl/pic_arbiter.sv
// Combinational arbiter: picks the highest-ranked eligible request and
// offers it only if it outranks the top in-service rank. Ordinary sources
// need their enable bit and the global enable; the non-maskable source and
// the trap need neither.
module pic_arbiter
    import pic_pkg::*;
(
    input  logic [SRC_N-1:0]    pend_q,
    input  logic [SRC_N-1:0]    mask_q,
    input  logic                glob_en,
    input  logic                nmi_pend_q,
    input  logic                trap_pend_q,
    input  logic [MAP_W-1:0]    map_q,
    input  logic                insvc_any,
    input  logic [ID_W-1:0]     insvc_top,
    output logic                irq,
    output logic [ID_W-1:0]     irq_id,
    output logic [ID_W-1:0]     irq_rank
);
    logic [SRC_N-1:0] elig;
    logic             cand_v;
    logic [ID_W-1:0]  cand_id;
    logic [ID_W-1:0]  cand_rank;

    assign elig = pend_q & mask_q & {SRC_N{glob_en}};

    // Scan levels upward so the highest eligible level wins, then fixed ranks.
    always_comb begin
        cand_v    = 1'b0;
        cand_id   = '0;
        cand_rank = '0;
        for (int l = 0; l < SRC_N; l++) begin
            if (elig[map_q[l*CODE_W +: CODE_W]]) begin
                cand_v    = 1'b1;
                cand_rank = ID_W'(l);
                cand_id   = ID_W'(map_q[l*CODE_W +: CODE_W]);
            end
        end
        if (nmi_pend_q) begin
            cand_v    = 1'b1;
            cand_rank = ID_W'(RANK_NMI);
            cand_id   = ID_W'(RANK_NMI);
        end
        if (trap_pend_q) begin
            cand_v    = 1'b1;
            cand_rank = ID_W'(RANK_TRAP);
            cand_id   = ID_W'(RANK_TRAP);
        end
    end

    // Offer the candidate only above the running service.
    always_comb begin
        irq      = cand_v && (!insvc_any || cand_rank > insvc_top);
        irq_id   = irq ? cand_id : '0;
        irq_rank = irq ? cand_rank : '0;
    end
endmodule

// File: rtl/pic_prio_ctrl.sv
// Top of the programmable priority interrupt controller. Connects the
// configuration registers, pending latches, in-service tracker and arbiter.
// Assumes the processor acknowledges only while irq is high and returns in
// strict nesting order, and that the map is reprogrammed with glob_en low.
module pic_prio_ctrl
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [7:0]        src_req,
    input  logic              nmi_req,
    input  logic              trap_req,
    input  logic              glob_en,
    input  logic              ack,
    input  logic              rti,
    input  logic              clr_valid,
    input  logic [2:0]        clr_code,
    output logic              irq,
    output logic [3:0]        irq_id,
    output logic [3:0]        irq_rank
);
    logic [SRC_N-1:0]             mask_q;
    logic [MAP_W-1:0]             map_q;
    logic [SRC_N-1:0][SRC_N-1:0]  src_lvl_oh;
    logic [SRC_N-1:0][CODE_W-1:0] src_lvl;
    logic [SRC_N-1:0]             pend_q;
    logic                         nmi_pend_q;
    logic                         trap_pend_q;
    logic [RANK_N-1:0]            insvc_q;
    logic                         insvc_any;
    logic [ID_W-1:0]              insvc_top;
    logic                         ack_fire;
    logic                         clr_block;

    assign ack_fire  = ack && irq;
    assign clr_block = insvc_q[src_lvl[clr_code]];

    pic_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .mask_q     (mask_q),
        .map_q      (map_q),
        .src_lvl_oh (src_lvl_oh),
        .src_lvl    (src_lvl)
    );

    pic_pending u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req     (src_req),
        .nmi_req     (nmi_req),
        .trap_req    (trap_req),
        .ack_fire    (ack_fire),
        .ack_id      (irq_id),
        .clr_valid   (clr_valid),
        .clr_code    (clr_code),
        .clr_block   (clr_block),
        .pend_q      (pend_q),
        .nmi_pend_q  (nmi_pend_q),
        .trap_pend_q (trap_pend_q)
    );

    pic_insvc u_isv (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_fire),
        .push_rank (irq_rank),
        .pop       (rti),
        .insvc_q   (insvc_q),
        .insvc_any (insvc_any),
        .insvc_top (insvc_top)
    );

    pic_arbiter u_arb (
        .pend_q      (pend_q),
        .mask_q      (mask_q),
        .glob_en     (glob_en),
        .nmi_pend_q  (nmi_pend_q),
        .trap_pend_q (trap_pend_q),
        .map_q       (map_q),
        .insvc_any   (insvc_any),
        .insvc_top   (insvc_top),
        .irq         (irq),
        .irq_id      (irq_id),
        .irq_rank    (irq_rank)
    );
endmodule

// File: rtl/pic_prio_chk.sv
// Checker for the priority interrupt controller, bound to the top. Relates
// the offered request to the in-service set, the enable word and the map.
module pic_prio_chk
    import pic_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          glob_en,
    input  logic                          ack,
    input  logic                          rti,
    input  logic                          irq,
    input  logic [ID_W-1:0]               irq_id,
    input  logic [ID_W-1:0]               irq_rank,
    input  logic [RANK_N-1:0]             insvc_q,
    input  logic [SRC_N-1:0]              mask_q,
    input  logic [SRC_N-1:0][SRC_N-1:0]   src_lvl_oh,
    input  logic                          nmi_pend_q
);
    logic [SRC_N-1:0] present;
    logic [ID_W-1:0]  rank_d;

    // Mark each source code that some level slot names.
    always_comb begin
        for (int s = 0; s < SRC_N; s++) present[s] = |src_lvl_oh[s];
    end

    // Remember the offered rank for the next-cycle check.
    always_ff @(posedge clk) begin
        if (!rst_n) rank_d <= '0;
        else        rank_d <= irq_rank;
    end

    a_r6_above_top: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (|insvc_q)) |-> (irq_rank > top_index(insvc_q)));

    a_r8_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        insvc_q[RANK_TRAP] |-> !irq);

    a_r5_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> insvc_q[rank_d]);

    a_r6_rti_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !ack && (|insvc_q)) |=>
        ($countones(insvc_q) == $past($countones(insvc_q)) - 1));

    a_r3_map_perm: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en |-> (&present));

    a_r7_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend_q && !insvc_q[RANK_NMI] && !insvc_q[RANK_TRAP]) |->
        (irq && irq_rank >= ID_W'(RANK_NMI)));

    a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_id < ID_W'(SRC_N)) |-> mask_q[irq_id[CODE_W-1:0]]);
endmodule

bind pic_prio_ctrl pic_prio_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_en    (glob_en),
    .ack        (ack),
    .rti        (rti),
    .irq        (irq),
    .irq_id     (irq_id),
    .irq_rank   (irq_rank),
    .insvc_q    (insvc_q),
    .mask_q     (mask_q),
    .src_lvl_oh (src_lvl_oh),
    .nmi_pend_q (nmi_pend_q)
);

// File: tb/pic_prio_ctrl_tb.sv
module pic_prio_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] src_req = '0;
    logic       nmi_req = 1'b0;
    logic       trap_req = 1'b0;
    logic       glob_en = 1'b0;
    logic       ack = 1'b0;
    logic       rti = 1'b0;
    logic       clr_valid = 1'b0;
    logic [2:0] clr_code = '0;
    logic       irq;
    logic [3:0] irq_id;
    logic [3:0] irq_rank;

    int checks = 0;
    int errors = 0;
    int perm [8];
    int lvl_of [8];

    always #10 clk = ~clk;

    pic_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .src_req(src_req), .nmi_req(nmi_req),
        .trap_req(trap_req), .glob_en(glob_en), .ack(ack), .rti(rti),
        .clr_valid(clr_valid), .clr_code(clr_code),
        .irq(irq), .irq_id(irq_id), .irq_rank(irq_rank)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic chk_req(input string tag, input int id, input int rank);
        chk({tag, " irq"}, irq, 1);
        chk({tag, " id"}, irq_id, id);
        chk({tag, " rank"}, irq_rank, rank);
    endtask

    task automatic cfg_write(input int addr, input int data);
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 8'(data);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_src(input int bits);
        src_req = 8'(bits); step(); src_req = '0;
    endtask

    task automatic pulse_nmi();
        nmi_req = 1'b1; step(); nmi_req = 1'b0;
    endtask

    task automatic pulse_trap();
        trap_req = 1'b1; step(); trap_req = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_rti();
        rti = 1'b1; step(); rti = 1'b0;
    endtask

    task automatic do_clr(input int code);
        clr_valid = 1'b1; clr_code = 3'(code); step(); clr_valid = 1'b0;
    endtask

    // Load perm[] (level -> code) with the global enable low.
    task automatic load_map();
        logic [23:0] m;
        m = '0;
        for (int l = 0; l < 8; l++) begin
            m[l*3 +: 3] = 3'(perm[l]);
            lvl_of[perm[l]] = l;
        end
        glob_en = 1'b0;
        cfg_write(2, int'(m[7:0]));
        cfg_write(3, int'(m[15:8]));
        cfg_write(4, int'(m[23:16]));
        glob_en = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got=0 exp=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        chk("R1 irq after reset", irq, 0);

        // R1/R3: default map, all sources at once drain from level 7 down.
        glob_en = 1'b1;
        cfg_write(0, 8'hFF);
        pulse_src(8'hFF);
        for (int k = 7; k >= 0; k--) begin
            chk_req("R1 R3 default order", k, k);
            do_ack();
            do_rti();
        end
        chk("R1 drained", irq, 0);

        // R2: masked request held, other addresses ignored, then unmasked.
        cfg_write(0, 8'h00);
        pulse_src(8'h08);
        chk("R2 masked silent", irq, 0);
        cfg_write(1, 8'hFF);
        cfg_write(5, 8'hFF);
        cfg_write(7, 8'hFF);
        chk("R2 other address ignored", irq, 0);
        cfg_write(0, 8'h08);
        chk_req("R2 unmask releases", 3, 3);
        do_ack(); do_rti();
        cfg_write(0, 8'hFF);

        // R4: global enable gates ordinary sources.
        glob_en = 1'b0;
        pulse_src(8'h40);
        chk("R4 global off", irq, 0);
        glob_en = 1'b1;
        step();
        chk_req("R4 global on", 6, 6);
        do_ack(); do_rti();

        // R5: ack with nothing offered changes nothing.
        do_ack();
        pulse_src(8'h01);
        chk_req("R5 stray ack ignored", 0, 0);
        do_ack();
        chk("R5 ack clears pending", irq, 0);
        do_rti();

        // R7/R8: three-deep chain ordinary -> NMI -> trap, global enable off.
        pulse_src(8'h80);
        do_ack();
        glob_en = 1'b0;
        pulse_nmi();
        chk_req("R7 nmi over level 7", 8, 8);
        do_ack();
        pulse_trap();
        chk_req("R8 trap over nmi", 9, 9);
        do_ack();
        pulse_nmi();
        chk("R8 trap not preempted", irq, 0);
        do_rti();
        chk("R6 nmi equal rank blocked", irq, 0);
        do_rti();
        chk_req("R6 R7 nmi after return", 8, 8);
        do_ack(); do_rti(); do_rti();
        chk("R6 chain unwound", irq, 0);
        pulse_trap();
        chk_req("R8 trap with global off", 9, 9);
        do_ack(); do_rti();
        cfg_write(0, 8'h00);
        pulse_nmi();
        chk_req("R7 nmi ignores enables", 8, 8);
        do_ack(); do_rti();
        glob_en = 1'b1;

        // R9: discard pending by code.
        pulse_src(8'h20);
        do_clr(5);
        cfg_write(0, 8'hFF);
        chk("R9 clear removes pending", irq, 0);
        cfg_write(0, 8'h00);
        pulse_src(8'h14);
        do_clr(4);
        cfg_write(0, 8'hFF);
        chk_req("R9 clear leaves others", 2, 2);
        do_ack(); do_rti();
        chk("R9 code 4 gone", irq, 0);
        pulse_src(8'h20);
        do_ack();
        pulse_src(8'h20);
        chk("R6 same source behind itself", irq, 0);
        do_clr(5);
        do_rti();
        chk_req("R9 clear blocked in service", 5, 5);
        do_ack(); do_rti();

        // R3/R6 sweep: all ordered pairs under four permutations.
        for (int p = 0; p < 4; p++) begin
            for (int l = 0; l < 8; l++) begin
                case (p)
                    0: perm[l] = l;
                    1: perm[l] = 7 - l;
                    2: perm[l] = (l * 3 + 1) % 8;
                    default: perm[l] = (l * 5 + 2) % 8;
                endcase
            end
            load_map();
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    int hi, lo;
                    if (a == b) continue;
                    hi = (lvl_of[a] > lvl_of[b]) ? a : b;
                    lo = (hi == a) ? b : a;
                    pulse_src((1 << a) | (1 << b));
                    chk_req("R3 pair winner", hi, lvl_of[hi]);
                    do_ack();
                    chk("R6 lower held", irq, 0);
                    do_rti();
                    chk_req("R6 lower after return", lo, lvl_of[lo]);
                    do_ack(); do_rti();
                    pulse_src(1 << a);
                    do_ack();
                    pulse_src(1 << b);
                    if (lvl_of[b] > lvl_of[a]) begin
                        chk_req("R6 preempt", b, lvl_of[b]);
                        do_ack(); do_rti();
                        chk("R6 resume idle", irq, 0);
                        do_rti();
                    end else begin
                        chk("R6 no preempt", irq, 0);
                        do_rti();
                        chk_req("R6 deferred", b, lvl_of[b]);
                        do_ack(); do_rti();
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule